// File: doc/BRIEF.md
# Programmable Skew Clock Output Matrix

This block is a cycle-level digital model of a four-pair clock fan-out matrix. It runs on a fast tick clock, and one tick is one time unit. An internal period counter produces a nominal clock whose period is N ticks. A range input selects N. Each output pair turns that nominal clock into its own waveform: a copy shifted by a whole number of ticks, a copy divided by two or by four, or an inverted copy. The choice depends on a pair of three-level selects per output pair.

Pairs 0 and 1 shift in steps of one tick over -4..+4. Pairs 2 and 3 shift in steps of two ticks over -6..+6. The two extreme codes of pairs 2 and 3 give the divided and inverted functions. All divided rising edges line up with the zero-shift rising edge.

A test input takes the period counter out of the path. A reference input then drives every output directly, and each pair still applies its own divide or invert function. Select and range changes are held until the next nominal period boundary.

Top module: `skew_clock_matrix`

## Requirements
- R1: Each select is 2 bits: 00 is low, 01 is mid, 10 is high, and 11 is also read as mid. Pair p uses pair_sel[4p+3:4p+2] as the first letter and pair_sel[4p+1:4p] as the second letter. The code index is 3*first+second, where low=0, mid=1 and high=2.
- R2: For pairs 0 and 1, code index i gives a shift of (i-4) ticks. A positive value delays the output.
- R3: For pairs 2 and 3, index 0 (LL) gives divide-by-2. Indices 1..7 give a shift of 2*(i-4) ticks.
- R4: Index 8 (HH) gives divide-by-4 on pair 2, and an inverted zero-shift clock on pair 3 (low for the first N/2 ticks of each period).
- R5: range_sel gives N: 00 gives 44, 10 gives 16, and 01 or 11 gives 26. Let t be the tick number, where t=0 is the first rising clock edge after reset is released. The zero-shift output is high for (t mod N) < N/2. It appears on q_out one tick later, after edge t+1. A shifted output is high when ((t mod N) - shift) mod N < N/2.
- R6: Divide-by-2 is high during even-numbered periods. Divide-by-4 is high during periods 4k and 4k+1. Every divided rising edge falls on the tick where a zero-shift output rises, and the first such edge is the first period after reset.
- R7: A change of pair_sel or range_sel takes effect only at the start of the next nominal period.
- R8: While rst is high (synchronous, active high), every output is low, and the period and divide counters are cleared.
- R9: While test_sel is not 00, each pair outputs ref_in delayed by two ticks. In this mode shift codes have no effect. The invert code outputs the complement of ref_in. Divide-by-2 and divide-by-4 count rising edges of ref_in from reset: divide-by-2 is high after odd counts, and divide-by-4 is high after counts 1 and 2 mod 4.
- R10: Both outputs of a pair (q_out[2p] and q_out[2p+1]) are always identical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one time unit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 2 | Three-level range select that sets N |
| test_sel | input | 2 | Three-level bypass select; 00 is normal operation |
| ref_in | input | 1 | Reference waveform used in bypass mode |
| pair_sel | input | 16 | Two three-level selects per pair, 4 bits per pair |
| q_out | output | 8 | Pair p drives bits 2p and 2p+1 |

## Verification
A wrong period counter or latched N shows up within one nominal period as an edge at the wrong tick on every pair at once. A wrong latched pair setting shows on that pair alone, also within one period. A corrupted divide counter can stay hidden for up to four periods, which is why each pattern is compared tick by tick over four full periods. A fault in the bypass path appears two ticks after the next edge of the reference.

// File: rtl/skm_pkg.sv
package skm_pkg;

  typedef enum logic [1:0] {
    LVL_LO  = 2'd0,
    LVL_MID = 2'd1,
    LVL_HI  = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    FN_SHIFT = 2'd0,
    FN_DIV2  = 2'd1,
    FN_DIV4  = 2'd2,
    FN_INV   = 2'd3
  } fn_e;

  typedef struct packed {
    fn_e               fn;
    logic signed [3:0] shift;
  } pair_cfg_t;

  // 11 is an illegal strap and is read as mid
  function automatic lvl_e to_lvl(input logic [1:0] raw);
    case (raw)
      2'b00:   return LVL_LO;
      2'b10:   return LVL_HI;
      default: return LVL_MID;
    endcase
  endfunction

endpackage

// File: rtl/skm_phase_gen.sv
module skm_phase_gen
  import skm_pkg::*;
#(
  parameter int N_LOW  = 44,
  parameter int N_MID  = 26,
  parameter int N_HIGH = 16,
  parameter int CW     = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    range_sel,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] n_cur,
  output logic          wrap,
  output logic [1:0]    per_cnt
);

  logic [CW-1:0] n_req;

  always_comb begin
    case (to_lvl(range_sel))
      LVL_LO:  n_req = CW'(N_LOW);
      LVL_HI:  n_req = CW'(N_HIGH);
      default: n_req = CW'(N_MID);
    endcase
  end

  assign wrap = (cnt == n_cur - 1'b1);

  // N is only reloaded on the last tick of a period
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      n_cur   <= n_req;
      per_cnt <= '0;
    end else if (wrap) begin
      cnt     <= '0;
      n_cur   <= n_req;
      per_cnt <= per_cnt + 2'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt < n_cur);

  assert_legal_period_R5: assert property (@(posedge clk) disable iff (rst)
    (n_cur == CW'(N_LOW)) || (n_cur == CW'(N_MID)) || (n_cur == CW'(N_HIGH)));

  assert_period_switch_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(n_cur) |-> (cnt == '0));

endmodule

// File: rtl/skm_decode.sv
module skm_decode
  import skm_pkg::*;
#(
  parameter bit WIDE_STEP   = 1'b0,
  parameter bit TOP_DIVIDES = 1'b0
) (
  input  logic [3:0] sel,
  output pair_cfg_t  cfg
);

  logic [3:0] idx;

  assign idx = 4'(3 * int'(to_lvl(sel[3:2])) + int'(to_lvl(sel[1:0])));

  if (WIDE_STEP) begin : g_wide
    always_comb begin
      cfg.fn    = FN_SHIFT;
      cfg.shift = '0;
      if (idx == 4'd0) begin
        cfg.fn = FN_DIV2;
      end else if (idx == 4'd8) begin
        cfg.fn = TOP_DIVIDES ? FN_DIV4 : FN_INV;
      end else begin
        cfg.shift = 4'(2 * (int'(idx) - 4));
      end
    end
  end else begin : g_fine
    always_comb begin
      cfg.fn    = FN_SHIFT;
      cfg.shift = 4'(int'(idx) - 4);
    end
  end

endmodule

// File: rtl/skm_pair.sv
module skm_pair
  import skm_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bypass,
  input  logic          wrap,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] n_cur,
  input  logic [1:0]    per_cnt,
  input  logic          ref_q,
  input  logic [1:0]    ref_per,
  input  pair_cfg_t     cfg_in,
  output logic [1:0]    q
);

  pair_cfg_t     cfg;
  logic [CW-1:0] half;
  int            ph;
  logic          tick_val;
  logic          ref_val;
  logic          nxt;
  logic          div_live;

  assign half = n_cur >> 1;

  // phase of the tick counter after removing the shift, wrapped into [0,N)
  always_comb begin
    int raw;
    raw = int'(cnt) - int'($signed(cfg.shift));
    if (raw < 0)
      raw = raw + int'(n_cur);
    else if (raw >= int'(n_cur))
      raw = raw - int'(n_cur);
    ph = raw;
  end

  always_comb begin
    case (cfg.fn)
      FN_DIV2: tick_val = (per_cnt[0] == 1'b0);
      FN_DIV4: tick_val = (per_cnt[1] == 1'b0);
      FN_INV:  tick_val = !(cnt < half);
      default: tick_val = (ph < int'(half));
    endcase
  end

  always_comb begin
    case (cfg.fn)
      FN_DIV2: ref_val = ref_per[0];
      FN_DIV4: ref_val = ref_per[1] ^ ref_per[0];
      FN_INV:  ref_val = !ref_q;
      default: ref_val = ref_q;
    endcase
  end

  assign nxt      = bypass ? ref_val : tick_val;
  assign div_live = !bypass && ((cfg.fn == FN_DIV2) || (cfg.fn == FN_DIV4));

  always_ff @(posedge clk) begin
    if (rst || wrap) cfg <= cfg_in;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 2'b00;
    else     q <= {2{nxt}};
  end

  assert_cfg_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg) |-> (cnt == '0));

  assert_reset_low_R8: assert property (@(posedge clk)
    rst |=> (q == 2'b00));

  assert_div_rise_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(div_live) && $past(!bypass, 2) && $rose(q[0])) |-> (cnt == CW'(1)));

endmodule

// File: rtl/skew_clock_matrix.sv
module skew_clock_matrix
  import skm_pkg::*;
#(
  parameter int N_LOW     = 44,
  parameter int N_MID     = 26,
  parameter int N_HIGH    = 16,
  parameter int NUM_PAIRS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             range_sel,
  input  logic [1:0]             test_sel,
  input  logic                   ref_in,
  input  logic [4*NUM_PAIRS-1:0] pair_sel,
  output logic [2*NUM_PAIRS-1:0] q_out
);

  localparam int N_MAX = (N_LOW > N_MID) ? ((N_LOW > N_HIGH) ? N_LOW : N_HIGH)
                                         : ((N_MID > N_HIGH) ? N_MID : N_HIGH);
  localparam int CW    = $clog2(N_MAX + 1);

  logic          bypass;
  logic [CW-1:0] cnt;
  logic [CW-1:0] n_cur;
  logic          wrap;
  logic [1:0]    per_cnt;
  logic          ref_q;
  logic [1:0]    ref_per;

  assign bypass = (test_sel != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= 1'b0;
      ref_per <= '0;
    end else begin
      ref_q <= ref_in;
      if (ref_in && !ref_q) ref_per <= ref_per + 2'd1;
    end
  end

  skm_phase_gen #(
    .N_LOW (N_LOW),
    .N_MID (N_MID),
    .N_HIGH(N_HIGH),
    .CW    (CW)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .range_sel(range_sel),
    .cnt      (cnt),
    .n_cur    (n_cur),
    .wrap     (wrap),
    .per_cnt  (per_cnt)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    pair_cfg_t cfg_w;

    skm_decode #(
      .WIDE_STEP  (p >= 2),
      .TOP_DIVIDES(p == 2)
    ) u_dec (
      .sel(pair_sel[4*p +: 4]),
      .cfg(cfg_w)
    );

    skm_pair #(
      .CW(CW)
    ) u_pair (
      .clk    (clk),
      .rst    (rst),
      .bypass (bypass),
      .wrap   (wrap),
      .cnt    (cnt),
      .n_cur  (n_cur),
      .per_cnt(per_cnt),
      .ref_q  (ref_q),
      .ref_per(ref_per),
      .cfg_in (cfg_w),
      .q      (q_out[2*p +: 2])
    );
  end

endmodule

// File: tb/skew_clock_matrix_tb_top.sv
module skew_clock_matrix_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  range_sel = 2'b10;
  logic [1:0]  test_sel = 2'b00;
  logic        ref_in = 1'b0;
  logic [15:0] pair_sel = 16'h5555;
  logic [7:0]  q_out;

  int checks = 0;
  int failures = 0;
  int tnow = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  skew_clock_matrix dut_i (
    .clk      (clk),
    .rst      (rst),
    .range_sel(range_sel),
    .test_sel (test_sel),
    .ref_in   (ref_in),
    .pair_sel (pair_sel),
    .q_out    (q_out)
  );

  // {range_sel, pair3, pair2, pair1, pair0}; letters L=00 M=01 H=10 X=11
  localparam logic [17:0] VEC_TAB [7] = '{
    {2'b10, 16'h5555},  // all zero shift (R5)
    {2'b10, 16'h91A0},  // -4 / +4 / -6 / +6
    {2'b01, 16'hA061},  // -3 / +1 / div2 / invert
    {2'b00, 16'h0A48},  // +2 / -1 / div4 / div2
    {2'b11, 16'h487F},  // 11 read as mid on range and selects (R1)
    {2'b10, 16'h2659},  // +3 / 0 / +2 / -4
    {2'b00, 16'hAAA0}   // -4 / +4 / div4 / invert
  };

  function automatic int lvl(input logic [1:0] r);
    return (r == 2'b00) ? 0 : ((r == 2'b10) ? 2 : 1);
  endfunction

  function automatic int n_of(input logic [1:0] r);
    return (r == 2'b00) ? 44 : ((r == 2'b10) ? 16 : 26);
  endfunction

  // 0 shift, 1 div2, 2 div4, 3 invert
  function automatic int mode_of(input int p, input logic [3:0] c, output int k);
    int i;
    i = 3 * lvl(c[3:2]) + lvl(c[1:0]);
    k = 0;
    if (p < 2) begin
      k = i - 4;
      return 0;
    end
    if (i == 0) return 1;
    if (i == 8) return (p == 2) ? 2 : 3;
    k = 2 * (i - 4);
    return 0;
  endfunction

  function automatic logic exp_norm(input int p, input logic [3:0] c, input int n, input int t);
    int k, m, cn, per, ph;
    m   = mode_of(p, c, k);
    cn  = t % n;
    per = t / n;
    case (m)
      1:       return (per % 2) == 0;
      2:       return (per % 4) < 2;
      3:       return cn >= n / 2;
      default: begin
        ph = ((cn - k) % n + n) % n;
        return ph < n / 2;
      end
    endcase
  endfunction

  function automatic logic exp_test(input int p, input logic [3:0] c, input logic rq,
                                    input logic [1:0] rp);
    int k, m;
    m = mode_of(p, c, k);
    case (m)
      1:       return rp[0];
      2:       return rp[1] ^ rp[0];
      3:       return !rq;
      default: return rq;
    endcase
  endfunction

  function automatic string tag_for(input int v, input int p, input logic [3:0] c);
    int k, m;
    if (v == 0) return "R5";
    if (v == 4) return "R1";
    m = mode_of(p, c, k);
    case (m)
      1:       return "R6";
      2:       return "R4";
      3:       return "R4";
      default: return (p < 2) ? "R2" : "R3";
    endcase
  endfunction

  task automatic chk_int(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    tnow++;
  endtask

  task automatic do_reset(input logic [1:0] rs, input logic [1:0] ts, input logic [15:0] ps);
    @(negedge clk);
    rst       = 1'b1;
    range_sel = rs;
    test_sel  = ts;
    pair_sel  = ps;
    ref_in    = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_int("R8", int'(q_out), 0, "outputs while reset held");
    rst  = 1'b0;
    tnow = 0;
  endtask

  task automatic run_test(input logic [1:0] ts, input logic [15:0] ps);
    logic       mref, rdrv, ex;
    logic [1:0] mper;
    int         bad [4];
    do_reset(2'b10, ts, ps);
    mref = 1'b0;
    mper = 2'b00;
    rdrv = 1'b0;
    bad  = '{default: 0};
    for (int m = 1; m <= 80; m++) begin
      step();
      for (int p = 0; p < 4; p++) begin
        ex = exp_test(p, ps[4*p +: 4], mref, mper);
        if (q_out[2*p] !== ex || q_out[2*p+1] !== ex) bad[p]++;
      end
      if (rdrv && !mref) mper = mper + 2'd1;
      mref   = rdrv;
      rdrv   = ((m / 5) % 2) == 1;
      ref_in = rdrv;
    end
    for (int p = 0; p < 4; p++)
      chk_int("R9", bad[p], 0, $sformatf("bypass pair %0d mismatching ticks", p));
  endtask

  initial begin
    logic [17:0] e;
    logic        ex;
    int          n;
    int          dup;
    int          bad [4];

    // table walk: every pattern compared tick by tick over four periods
    for (int v = 0; v < 7; v++) begin
      e = VEC_TAB[v];
      n = n_of(e[17:16]);
      do_reset(e[17:16], 2'b00, e[15:0]);
      bad = '{default: 0};
      dup = 0;
      for (int t = 0; t < 4 * n + 4; t++) begin
        step();
        for (int p = 0; p < 4; p++) begin
          ex = exp_norm(p, e[4*p +: 4], n, t);
          if (q_out[2*p] !== ex) bad[p]++;
          if (q_out[2*p+1] !== q_out[2*p]) dup++;
        end
      end
      for (int p = 0; p < 4; p++)
        chk_int(tag_for(v, p, e[4*p +: 4]), bad[p], 0,
                $sformatf("vector %0d pair %0d mismatching ticks", v, p));
      chk_int("R10", dup, 0, $sformatf("vector %0d pair outputs differ", v));
    end

    // R7: select change in mid period waits for the boundary
    do_reset(2'b10, 2'b00, 16'h5555);
    while (tnow < 5) step();
    pair_sel[3:0] = 4'b1010;
    while (tnow < 12) step();
    chk_int("R7", int'(q_out[0]), 0, "shift applied before period end");
    while (tnow < 17) step();
    chk_int("R7", int'(q_out[0]), 0, "new +4 shift at period start");
    while (tnow < 21) step();
    chk_int("R7", int'(q_out[0]), 1, "new +4 shift rising edge");

    // R5/R7: range change from 16 to 44 at the boundary
    do_reset(2'b10, 2'b00, 16'h5555);
    while (tnow < 3) step();
    range_sel = 2'b00;
    while (tnow < 13) step();
    chk_int("R7", int'(q_out[0]), 0, "old period still running");
    while (tnow < 31) step();
    chk_int("R5", int'(q_out[0]), 1, "first half of 44-tick period");
    while (tnow < 39) step();
    chk_int("R5", int'(q_out[0]), 0, "second half of 44-tick period");
    while (tnow < 60) step();
    chk_int("R5", int'(q_out[0]), 0, "last tick of 44-tick period");
    while (tnow < 61) step();
    chk_int("R5", int'(q_out[0]), 1, "next 44-tick period rises");

    // R9: bypass with skew ignored, div2, invert, div4
    run_test(2'b01, 16'hA0A5);
    run_test(2'b10, 16'h1A60);
    run_test(2'b11, 16'h5555);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule